// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block takes a processor from ordinary execution into an exception handler. Four kinds of event can start an entry: a bus fault reported by the address translator, a non-maskable interrupt, a break trap, and a maskable interrupt. The block accepts at most one of them while it is idle. It selects a vector number and saves the return address. It then rewrites the status word into its saved-state layout and swaps to the kernel stack if the core was in user mode. It reads the handler address from a vector table in memory and hands it to the core as the new program counter.

The state machine has five named states. `ST_IDLE` waits for an accepted request and goes to `ST_SAVE`. `ST_SAVE` writes the return register, the exception-status register and the fault address, then goes to `ST_STATUS`. `ST_STATUS` writes the status word and the stack registers, then goes to `ST_FETCH`. `ST_FETCH` holds the memory read until valid data arrives, then goes to `ST_DONE`. `ST_DONE` gives the core its new PC for one cycle and returns to `ST_IDLE`. The register file, instruction decode and translation hardware sit outside the block. The block reads their values on input ports and writes them back through write strobes.

Top module: `exc_entry_seq`

## Requirements
- R1: A maskable interrupt is accepted only when bit 5 (interrupt enable) of `sr_in` is 1 and `irq_locked` is 0. Otherwise the block stays idle and writes nothing.
- R2: A non-maskable interrupt is accepted only when bit 30 (NMI enable) of `sr_in` is 1. It uses vector 0 and saves the return address with `nrp_we`. The NMI-enable bit is cleared before the status rewrite.
- R3: A break uses `brk_vec`, a bus fault uses `bus_fault_vec` and a maskable interrupt uses `irq_vec`. Each of these saves the return address with `erp_we`.
- R4: When several requests are accepted in the same cycle, the order of priority is bus fault, then NMI, then break, then maskable interrupt.
- R5: `exs_out` carries the chosen vector in bits 15:8. All other bits are 0.
- R6: The saved return address is `cur_pc - dslot_cnt`. `dslot_clr` pulses in the save cycle exactly when `dslot_cnt` was non-zero at acceptance.
- R7: If bit 8 (user mode) of `sr_in` is 1 in the status cycle, `usp_out` gets `sp_in` and `sp_out` gets `ksp_in`, each with its strobe. If the bit is 0, neither strobe fires.
- R8: The new status word is formed from the old word S as follows: bits 31:30 are kept, bits 19:0 of S move to bits 29:10, and bits 9:0 are 0.
- R9: The handler address is read from `base_in + 4*vector`, with 32-bit wraparound. `mem_req` and `mem_addr` are held until `mem_rvalid`. `pc_out` then carries `mem_rdata` with a one-cycle `pc_we`.
- R10: For a request sampled at clock edge k, the save writes appear in cycle k+1 and the status writes in cycle k+2. `mem_req` rises in cycle k+3. `pc_we` comes one cycle after the edge that sees `mem_rvalid`. Requests that arrive while busy are ignored.
- R11: On an accepted bus fault, `fault_addr_out` carries `bus_fault_addr` as it was at acceptance, with `fault_addr_we` in the save cycle.
- R12: A bus fault request seen while a bus-fault entry is in progress sets `abort`, which stays set until reset. A bus fault that comes after an entry has finished starts a new entry without abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | 8 | Vector from the interrupt controller |
| irq_locked | input | 1 | An interrupt is already locked in |
| nmi_req | input | 1 | Non-maskable interrupt request |
| brk_req | input | 1 | Break trap request |
| brk_vec | input | 8 | Vector supplied with the trap |
| bus_fault_req | input | 1 | Translation miss (bus fault) |
| bus_fault_vec | input | 8 | Fault vector from the translator |
| bus_fault_addr | input | 32 | Faulting address |
| cur_pc | input | 32 | Current program counter |
| dslot_cnt | input | 2 | Pending delay-slot byte count |
| sr_in | input | 32 | Current status word |
| sr_we | output | 1 | Status word write strobe |
| sr_out | output | 32 | New status word |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack register |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 32 | New stack pointer |
| usp_we | output | 1 | User-stack register write strobe |
| usp_out | output | 32 | Value for the user-stack register |
| ret_addr | output | 32 | Return address being saved |
| erp_we | output | 1 | Write strobe for the exception return register |
| nrp_we | output | 1 | Write strobe for the NMI return register |
| exs_we | output | 1 | Exception-status write strobe |
| exs_out | output | 32 | Exception-status value |
| fault_addr_we | output | 1 | Fault-address write strobe |
| fault_addr_out | output | 32 | Fault address |
| dslot_clr | output | 1 | Clear the delay-slot state |
| base_in | input | 32 | Vector table base |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pc_we | output | 1 | New PC valid (done pulse) |
| pc_out | output | 32 | Handler address |
| busy | output | 1 | Entry in progress |
| abort | output | 1 | Recursive bus fault, sticky |

## Verification
The assertions check properties that must hold in every cycle:
- A masked interrupt never starts an entry.
- The two return strobes are never active together.
- An NMI always records vector 0.
- The exception-status word keeps its zero fields.
- The status rewrite clears its low bits.
- The read request stays stable while it waits for data.
- The save writes are followed by the status write.
- The done pulse lasts one cycle.
- Abort rises only after a bus fault arrives during a bus-fault entry.

The bench covers every combination of requests, enable flags, lock, user mode and delay-slot count. It checks the exact return addresses, the priority choice of vector, the status bit movement, the stack swap, the table address including wraparound, the done timing under different memory latencies, the sticky abort, and that requests arriving while busy are dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_STATUS,
        ST_FETCH,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_IRQ,
        CAUSE_BRK,
        CAUSE_NMI,
        CAUSE_BFLT
    } cause_e;

endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             irq_req,
    input  logic             irq_ok,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             nmi_req,
    input  logic             nmi_ok,
    input  logic             brk_req,
    input  logic [VEC_W-1:0] brk_vec,
    input  logic             bflt_req,
    input  logic [VEC_W-1:0] bflt_vec,
    output logic             take,
    output cause_e           cause,
    output logic [VEC_W-1:0] vec
);

    // Fixed priority: bus fault, NMI, break, maskable interrupt.
    always_comb begin
        take  = 1'b1;
        cause = CAUSE_IRQ;
        vec   = '0;
        if (bflt_req) begin
            cause = CAUSE_BFLT;
            vec   = bflt_vec;
        end else if (nmi_req && nmi_ok) begin
            cause = CAUSE_NMI;
            vec   = '0;
        end else if (brk_req) begin
            cause = CAUSE_BRK;
            vec   = brk_vec;
        end else if (irq_req && irq_ok) begin
            cause = CAUSE_IRQ;
            vec   = irq_vec;
        end else begin
            take  = 1'b0;
        end
    end

endmodule

// File: rtl/exc_status_xform.sv
module exc_status_xform #(
    parameter int XLEN     = 32,
    parameter int NMIE_BIT = 30,
    parameter int KEEP_W   = 2,
    parameter int CLR_W    = 10
) (
    input  logic [XLEN-1:0] sr_old,
    input  logic            clr_nmie,
    output logic [XLEN-1:0] sr_new
);

    localparam int MOVE_W = XLEN - KEEP_W - CLR_W;

    logic [XLEN-1:0] sr_pre;

    always_comb begin
        sr_pre = sr_old;
        if (clr_nmie) begin
            sr_pre[NMIE_BIT] = 1'b0;
        end
    end

    // Keep the top field, push the low field up into saved positions,
    // and zero the live flag area.
    assign sr_new = {sr_pre[XLEN-1 -: KEEP_W], sr_pre[MOVE_W-1:0], {CLR_W{1'b0}}};

endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_en,
    input  logic [XLEN-1:0]  base,
    input  logic [VEC_W-1:0] vec,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  handler
);

    localparam int PAD_W = XLEN - VEC_W - 2;

    logic [XLEN-1:0] handler_q;

    assign mem_req  = fetch_en;
    assign mem_addr = base + {{PAD_W{1'b0}}, vec, 2'b00};
    assign handler  = handler_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            handler_q <= '0;
        end else if (fetch_en && mem_rvalid) begin
            handler_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 8,
    parameter int DSLOT_W  = 2,
    parameter int IE_BIT   = 5,
    parameter int USER_BIT = 8,
    parameter int NMIE_BIT = 30,
    parameter int KEEP_W   = 2,
    parameter int CLR_W    = 10,
    parameter int EXS_LSB  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             irq_locked,
    input  logic             nmi_req,
    input  logic             brk_req,
    input  logic [VEC_W-1:0] brk_vec,
    input  logic             bus_fault_req,
    input  logic [VEC_W-1:0] bus_fault_vec,
    input  logic [XLEN-1:0]  bus_fault_addr,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [DSLOT_W-1:0] dslot_cnt,
    input  logic [XLEN-1:0]  sr_in,
    output logic             sr_we,
    output logic [XLEN-1:0]  sr_out,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  ksp_in,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_out,
    output logic             usp_we,
    output logic [XLEN-1:0]  usp_out,
    output logic [XLEN-1:0]  ret_addr,
    output logic             erp_we,
    output logic             nrp_we,
    output logic             exs_we,
    output logic [XLEN-1:0]  exs_out,
    output logic             fault_addr_we,
    output logic [XLEN-1:0]  fault_addr_out,
    output logic             dslot_clr,
    input  logic [XLEN-1:0]  base_in,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_out,
    output logic             busy,
    output logic             abort
);

    localparam int EXS_HI_W = XLEN - EXS_LSB - VEC_W;
    localparam int DS_PAD_W = XLEN - DSLOT_W;

    seq_state_e          state_q, state_d;
    cause_e              cause_q;
    logic [VEC_W-1:0]    vec_q;
    logic [XLEN-1:0]     ret_q;
    logic [XLEN-1:0]     fault_addr_q;
    logic                dslot_q;
    logic                live_q;
    logic                abort_q;

    logic                arb_take;
    cause_e              arb_cause;
    logic [VEC_W-1:0]    arb_vec;
    logic [XLEN-1:0]     sr_xf;
    logic [XLEN-1:0]     handler;
    logic                accept;

    exc_req_arbiter #(.VEC_W(VEC_W)) u_arb (
        .irq_req  (irq_req),
        .irq_ok   (sr_in[IE_BIT] && !irq_locked),
        .irq_vec  (irq_vec),
        .nmi_req  (nmi_req),
        .nmi_ok   (sr_in[NMIE_BIT]),
        .brk_req  (brk_req),
        .brk_vec  (brk_vec),
        .bflt_req (bus_fault_req),
        .bflt_vec (bus_fault_vec),
        .take     (arb_take),
        .cause    (arb_cause),
        .vec      (arb_vec)
    );

    exc_status_xform #(
        .XLEN(XLEN), .NMIE_BIT(NMIE_BIT), .KEEP_W(KEEP_W), .CLR_W(CLR_W)
    ) u_xf (
        .sr_old   (sr_in),
        .clr_nmie (cause_q == CAUSE_NMI),
        .sr_new   (sr_xf)
    );

    exc_vec_fetch #(.XLEN(XLEN), .VEC_W(VEC_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (state_q == ST_FETCH),
        .base       (base_in),
        .vec        (vec_q),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .handler    (handler)
    );

    assign accept = (state_q == ST_IDLE) && arb_take;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arb_take) state_d = ST_SAVE;
            ST_SAVE:   state_d = ST_STATUS;
            ST_STATUS: state_d = ST_FETCH;
            ST_FETCH:  if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and entry context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cause_q      <= CAUSE_IRQ;
            vec_q        <= '0;
            ret_q        <= '0;
            fault_addr_q <= '0;
            dslot_q      <= 1'b0;
            live_q       <= 1'b0;
            abort_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cause_q      <= arb_cause;
                vec_q        <= arb_vec;
                ret_q        <= cur_pc - {{DS_PAD_W{1'b0}}, dslot_cnt};
                dslot_q      <= (dslot_cnt != '0);
                fault_addr_q <= bus_fault_addr;
                live_q       <= 1'b1;
            end else if (state_q == ST_DONE) begin
                live_q       <= 1'b0;
            end
            if (live_q && cause_q == CAUSE_BFLT && bus_fault_req) begin
                abort_q <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        erp_we         = 1'b0;
        nrp_we         = 1'b0;
        exs_we         = 1'b0;
        fault_addr_we  = 1'b0;
        dslot_clr      = 1'b0;
        sr_we          = 1'b0;
        sp_we          = 1'b0;
        usp_we         = 1'b0;
        pc_we          = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SAVE: begin
                erp_we        = (cause_q != CAUSE_NMI);
                nrp_we        = (cause_q == CAUSE_NMI);
                exs_we        = 1'b1;
                fault_addr_we = (cause_q == CAUSE_BFLT);
                dslot_clr     = dslot_q;
            end
            ST_STATUS: begin
                sr_we  = 1'b1;
                sp_we  = sr_in[USER_BIT];
                usp_we = sr_in[USER_BIT];
            end
            ST_FETCH: ;
            ST_DONE: pc_we = 1'b1;
            default: ;
        endcase
    end

    assign ret_addr       = ret_q;
    assign exs_out        = {{EXS_HI_W{1'b0}}, vec_q, {EXS_LSB{1'b0}}};
    assign fault_addr_out = fault_addr_q;
    assign sr_out         = sr_xf;
    assign sp_out         = ksp_in;
    assign usp_out        = sp_in;
    assign pc_out         = handler;
    assign busy           = (state_q != ST_IDLE);
    assign abort          = abort_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 8,
    parameter int IE_BIT   = 5,
    parameter int CLR_W    = 10,
    parameter int EXS_LSB  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic            irq_locked,
    input logic            nmi_req,
    input logic            brk_req,
    input logic            bus_fault_req,
    input logic [XLEN-1:0] sr_in,
    input logic            busy,
    input logic            erp_we,
    input logic            nrp_we,
    input logic            exs_we,
    input logic [XLEN-1:0] exs_out,
    input logic            sr_we,
    input logic [XLEN-1:0] sr_out,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            pc_we,
    input logic            abort
);

    localparam int EXS_HI = EXS_LSB + VEC_W;

    a_r1_masked_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && (!sr_in[IE_BIT] || irq_locked)
         && !nmi_req && !brk_req && !bus_fault_req) |=> !busy);

    a_r3_one_return_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(erp_we && nrp_we));

    a_r2_nmi_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nrp_we |-> (exs_we && exs_out[EXS_HI-1:EXS_LSB] == '0));

    a_r5_exs_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        exs_we |-> (exs_out[XLEN-1:EXS_HI] == '0 && exs_out[EXS_LSB-1:0] == '0));

    a_r8_status_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (sr_out[CLR_W-1:0] == '0));

    a_r9_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r10_save_then_status: assert property (@(posedge clk) disable iff (!rst_n)
        (erp_we || nrp_we) |=> sr_we);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !pc_we);

    a_r12_abort_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> $past(busy && bus_fault_req));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN(XLEN), .VEC_W(VEC_W), .IE_BIT(IE_BIT), .CLR_W(CLR_W), .EXS_LSB(EXS_LSB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .irq_locked    (irq_locked),
    .nmi_req       (nmi_req),
    .brk_req       (brk_req),
    .bus_fault_req (bus_fault_req),
    .sr_in         (sr_in),
    .busy          (busy),
    .erp_we        (erp_we),
    .nrp_we        (nrp_we),
    .exs_we        (exs_we),
    .exs_out       (exs_out),
    .sr_we         (sr_we),
    .sr_out        (sr_out),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .pc_we         (pc_we),
    .abort         (abort)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 0, irq_locked = 0, nmi_req = 0, brk_req = 0, bus_fault_req = 0;
    logic [7:0]  irq_vec = 0, brk_vec = 0, bus_fault_vec = 0;
    logic [31:0] bus_fault_addr = 0, cur_pc = 0, sr_in = 0, sp_in = 0, ksp_in = 0, base_in = 0;
    logic [1:0]  dslot_cnt = 0;
    logic        mem_rvalid = 0;
    logic [31:0] mem_rdata = 0;
    logic        sr_we, sp_we, usp_we, erp_we, nrp_we, exs_we, fault_addr_we, dslot_clr;
    logic        mem_req, pc_we, busy, abort;
    logic [31:0] sr_out, sp_out, usp_out, ret_addr, exs_out, fault_addr_out, mem_addr, pc_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_locked(irq_locked),
        .nmi_req(nmi_req), .brk_req(brk_req), .brk_vec(brk_vec),
        .bus_fault_req(bus_fault_req), .bus_fault_vec(bus_fault_vec),
        .bus_fault_addr(bus_fault_addr), .cur_pc(cur_pc), .dslot_cnt(dslot_cnt),
        .sr_in(sr_in), .sr_we(sr_we), .sr_out(sr_out),
        .sp_in(sp_in), .ksp_in(ksp_in), .sp_we(sp_we), .sp_out(sp_out),
        .usp_we(usp_we), .usp_out(usp_out), .ret_addr(ret_addr),
        .erp_we(erp_we), .nrp_we(nrp_we), .exs_we(exs_we), .exs_out(exs_out),
        .fault_addr_we(fault_addr_we), .fault_addr_out(fault_addr_out),
        .dslot_clr(dslot_clr), .base_in(base_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_out(pc_out),
        .busy(busy), .abort(abort)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog R10 act=%0d exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    // One entry attempt. intrude: 1 = NMI pulse while busy, 2 = bus fault pulse while busy.
    task automatic run_one(input bit ir, input bit nr, input bit br, input bit fr,
                           input bit ie, input bit nmie, input bit usr, input bit lk,
                           input int ds, input int lat, input int idx, input int intrude);
        logic [31:0] pat, s, exp_sr, exp_ret, exp_addr;
        logic [7:0]  exp_vec;
        int          kind;  // 0 none, 1 irq, 2 brk, 3 nmi, 4 bflt
        int          wcnt, save_c, status_c, done_c, req_c;
        logic [31:0] got_ret, got_exs, got_sr, got_usp, got_sp, got_fa, got_addr, got_pc;
        bit          got_erp, got_nrp, got_dclr, got_fawe, got_usp_we, got_sp_we, stray;

        pat = 32'h9E37_79B9 * (idx + 1);
        s = pat;
        s[5] = ie; s[30] = nmie; s[8] = usr;
        sr_in = s;
        irq_vec = 8'h40 + idx[7:0];
        brk_vec = 8'h80 ^ idx[7:0];
        bus_fault_vec = 8'hC3 + idx[7:0];
        bus_fault_addr = 32'hDEAD_0000 + idx;
        cur_pc = 32'h0000_1000 + idx * 6;
        sp_in = 32'h7FFF_F000 - idx;
        ksp_in = 32'h8000_2000 + idx;
        base_in = (idx % 5 == 0) ? 32'hFFFF_FFF0 : 32'h0004_0000 + idx * 16;
        dslot_cnt = ds[1:0];
        irq_locked = lk;
        irq_req = ir; nmi_req = nr; brk_req = br; bus_fault_req = fr;

        kind = 0; exp_vec = 8'h00;
        if (fr) begin kind = 4; exp_vec = bus_fault_vec; end
        else if (nr && nmie) begin kind = 3; exp_vec = 8'h00; end
        else if (br) begin kind = 2; exp_vec = brk_vec; end
        else if (ir && ie && !lk) begin kind = 1; exp_vec = irq_vec; end

        exp_ret = cur_pc - ds;
        s = sr_in;
        if (kind == 3) s[30] = 1'b0;
        exp_sr = {s[31:30], s[19:0], 10'b0};
        exp_addr = base_in + {22'b0, exp_vec, 2'b00};

        save_c = 0; status_c = 0; done_c = 0; req_c = 0; wcnt = 0; stray = 0;
        got_erp = 0; got_nrp = 0; got_dclr = 0; got_fawe = 0; got_usp_we = 0; got_sp_we = 0;
        got_ret = 0; got_exs = 0; got_sr = 0; got_usp = 0; got_sp = 0; got_fa = 0;
        got_addr = 0; got_pc = 0;

        for (int c = 1; c <= 14; c++) begin
            @(negedge clk);
            if (erp_we || nrp_we) begin
                if (save_c != 0) stray = 1;
                save_c = c; got_erp = erp_we; got_nrp = nrp_we; got_ret = ret_addr;
                got_exs = exs_out; got_dclr = dslot_clr; got_fawe = fault_addr_we;
                got_fa = fault_addr_out;
            end
            if (sr_we) begin
                status_c = c; got_sr = sr_out; got_usp_we = usp_we; got_sp_we = sp_we;
                got_usp = usp_out; got_sp = sp_out;
            end
            if (pc_we) begin
                if (done_c != 0) stray = 1;
                done_c = c; got_pc = pc_out;
            end
            if (c == 1) begin
                irq_req = 0; nmi_req = 0; brk_req = 0; bus_fault_req = 0;
            end
            if (c == 2 && intrude == 1) begin nmi_req = 1; sr_in[30] = 1'b1; end
            if (c == 2 && intrude == 2) bus_fault_req = 1;
            if (c == 3) begin nmi_req = 0; bus_fault_req = 0; sr_in = s; sr_in[30] = nmie; end
            if (mem_rvalid) mem_rvalid = 0;
            else if (mem_req) begin
                if (req_c == 0) begin req_c = c; got_addr = mem_addr; end
                if (wcnt == lat) begin mem_rvalid = 1; mem_rdata = mem_fn(mem_addr); end
                else wcnt++;
            end
        end

        if (kind == 0) begin
            chk(save_c == 0 && done_c == 0 && status_c == 0, ir ? "R1 masked" : "R2 masked",
                {16'b0, 8'(save_c), 8'(done_c)}, 32'h0);
            return;
        end
        chk(save_c == 1 && !stray, "R10 save cycle", save_c, 1);
        chk(status_c == 2, "R10 status cycle", status_c, 2);
        chk(req_c == 3, "R10 fetch start", req_c, 3);
        chk(done_c == 4 + lat, "R10 done cycle", done_c, 4 + lat);
        chk(got_nrp == (kind == 3), "R2 nmi return strobe", got_nrp, kind == 3);
        chk(got_erp == (kind != 3), "R3 exception return strobe", got_erp, kind != 3);
        chk(got_ret == exp_ret, "R6 return address", got_ret, exp_ret);
        chk(got_dclr == (ds != 0), "R6 delay slot clear", got_dclr, ds != 0);
        chk(got_exs[15:8] == exp_vec, "R4 chosen vector", got_exs[15:8], exp_vec);
        chk(got_exs == {16'b0, exp_vec, 8'b0}, "R5 status format", got_exs, {16'b0, exp_vec, 8'b0});
        chk(got_sr == exp_sr, "R8 status rewrite", got_sr, exp_sr);
        chk(got_usp_we == usr && got_sp_we == usr, "R7 swap strobes", {got_usp_we, got_sp_we}, {usr, usr});
        if (usr) begin
            chk(got_usp == sp_in && got_sp == ksp_in, "R7 swap values", got_sp, ksp_in);
        end
        chk(got_addr == exp_addr, "R9 table address", got_addr, exp_addr);
        chk(got_pc == mem_fn(exp_addr), "R9 handler", got_pc, mem_fn(exp_addr));
        chk(got_fawe == (kind == 4), "R11 fault strobe", got_fawe, kind == 4);
        if (kind == 4) chk(got_fa == 32'hDEAD_0000 + idx, "R11 fault address", got_fa, 32'hDEAD_0000 + idx);
        if (kind == 3 || kind == 2 || kind == 1) chk(kind != 3 || exp_vec == 0, "R3 vector source", exp_vec, 0);
        if (intrude == 1) chk(!stray && done_c == 4 + lat, "R10 busy ignores request", stray, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !pc_we && !mem_req && !abort && !sr_we, "R10 reset state",
            {busy, pc_we, mem_req, abort}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int idx = 0; idx < 768; idx++) begin
            run_one(idx[0], idx[1], idx[2], idx[3], idx[4], idx[5], idx[6], idx[7],
                    idx % 3, (idx / 3) % 3, idx, 0);
        end

        // Requests during a busy entry are dropped (R10)
        run_one(0, 0, 1, 0, 0, 1, 0, 0, 0, 1, 900, 1);
        run_one(1, 0, 0, 0, 1, 0, 1, 0, 2, 2, 901, 1);

        // Bus fault during a break entry: not recursive (R12)
        run_one(0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 902, 2);
        @(negedge clk);
        chk(!abort, "R12 no abort for non-fault entry", abort, 0);

        // Fault after a finished fault entry: not recursive (R12)
        run_one(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 903, 0);
        run_one(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 904, 0);
        @(negedge clk);
        chk(!abort, "R12 sequential faults", abort, 0);

        // Recursive fault raises sticky abort (R12)
        run_one(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 905, 2);
        @(negedge clk);
        chk(abort, "R12 recursive fault abort", abort, 1);
        repeat (5) @(negedge clk);
        chk(abort, "R12 abort sticky", abort, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule